// File: doc/BRIEF.md
# Nibble-Bus Display RAM Host Port

This block lets a host reach a 4-bit-wide store of display and scratch nibbles over a narrow asynchronous bus. The bus has these lines:

- an active-low port enable;
- an address/data select line;
- active-low write and read strobes;
- a bidirectional 4-bit data path.

The host first sends the location as three nibbles on the shared data lines, most significant first. It then raises the select line and moves any number of data nibbles. An internal counter steps the location by one after each access.

All host lines are brought into the system clock domain through a synchronizer chain before their edges are detected. A write lands on the rising edge of the synchronized write strobe. A read presents the nibble at the current location while the strobe is low, and steps the location when the strobe rises.

The location just past the storage array is a 4-bit control word. Its low three bits pick one of eight regulator levels and its top bit picks the bias reference. A second, independent read port lets the display scan logic fetch nibbles without disturbing the host.

Top module: `nibble_ram_port`

## Requirements
- R1: While port_en_n is high, write and read strobes change neither the stored nibbles nor the location counter, and the block never drives the bus.
- R2: With sel_data low, each rising write strobe loads one address nibble. The three nibbles fill bits 11:8, then 7:4, then 3:0 of the location.
- R3: The address nibble position returns to the first nibble (bits 11:8) when sel_data falls or when port_en_n rises.
- R4: With sel_data high, each rising write strobe stores the bus nibble at the current location and then advances the location by one.
- R5: With sel_data high, the bus carries the nibble at the current location while rd_n is low. Each rising read strobe advances the location by one.
- R6: The block drives the bus only while port_en_n is low, rd_n is low and sel_data is high. At all other times its bus driver is off.
- R7: Location 2560 is the control word, reset to 0. Its bits 2:0 appear on reg_level and its bit 3 appears on bias_sel. It is written and read like any other location.
- R8: The location counter stops at 2560 and does not advance past it. Accesses at a location above 2560 store nothing and do not move the counter, and reads there return 0.
- R9: scan_data shows, one clock after scan_addr is applied, the nibble stored at scan_addr. It shows the control word for 2560 and 0 above 2560.
- R10: After reset, reg_level and bias_sel are 0 and the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en_n | input | 1 | Active-low host port enable |
| sel_data | input | 1 | Low: bus carries address nibbles; high: data nibbles |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| bus | inout | 4 | Bidirectional nibble bus |
| scan_addr | input | 12 | Display scan read location |
| scan_data | output | 4 | Nibble at scan_addr, one clock later |
| reg_level | output | 3 | Control word bits 2:0, regulator level |
| bias_sel | output | 1 | Control word bit 3, bias reference select |

## Verification
The bench sends a single address nibble and then aborts the address phase, once by toggling the select line and once by pulsing the enable. A design that kept its nibble position would then load a shifted location. Bursts that run from 2559 into the control word, and accesses at 2561, show whether the counter wraps, or whether a write at an illegal location corrupts the control word or the array. Strobes sent while the port is disabled are followed by a read at the same location: a design that leaks them shows a changed nibble or an advanced counter. For the bus-release checks, the bench drives the complement of the stored nibble, so a design that wrongly drives the bus gives a conflicting value.

// File: rtl/nrp_pkg.sv
package nrp_pkg;
   localparam int NRP_NIB_W = 4;

   typedef struct packed {
      logic       bias_sel;
      logic [2:0] level;
   } nrp_ctrl_t;

   localparam int NRP_CTRL_W = $bits(nrp_ctrl_t);
endpackage

// File: rtl/nrp_sync.sv
module nrp_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("nrp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/nrp_seq.sv
module nrp_seq #(
   parameter int NIB_W     = 4,
   parameter int ADDR_W    = 12,
   parameter int CTRL_ADDR = 2560
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_n_s,
   input  logic              sel_s,
   input  logic              wr_n_s,
   input  logic              rd_n_s,
   input  logic [NIB_W-1:0]  data_s,
   output logic [ADDR_W-1:0] addr_o,
   output logic              we_o,
   output logic [NIB_W-1:0]  wdata_o
);
   localparam int NIBS  = ADDR_W / NIB_W;
   localparam int POS_W = (NIBS > 1) ? $clog2(NIBS) : 1;
   localparam logic [POS_W-1:0]  LAST_POS = POS_W'(NIBS - 1);
   localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(CTRL_ADDR);

   generate
      if (ADDR_W % NIB_W != 0) begin : g_bad_split
         $error("nrp_seq: ADDR_W must be a multiple of NIB_W");
      end
      if (CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_ctrl
         $error("nrp_seq: CTRL_ADDR does not fit in ADDR_W");
      end
   endgenerate

   logic              prev_en_n, prev_sel, prev_wr_n, prev_rd_n;
   logic [ADDR_W-1:0] addr_q;
   logic [POS_W-1:0]  pos_q;
   logic              active, wr_rise, rd_rise, sel_fall, en_rise;
   logic              data_evt, in_range;

   assign active   = !en_n_s;
   assign wr_rise  = wr_n_s && !prev_wr_n;
   assign rd_rise  = rd_n_s && !prev_rd_n;
   assign sel_fall = !sel_s && prev_sel;
   assign en_rise  = en_n_s && !prev_en_n;
   assign data_evt = active && sel_s && (wr_rise || rd_rise);
   assign in_range = (addr_q <= CTRL_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_en_n <= 1'b1;
         prev_sel  <= 1'b0;
         prev_wr_n <= 1'b1;
         prev_rd_n <= 1'b1;
      end else begin
         prev_en_n <= en_n_s;
         prev_sel  <= sel_s;
         prev_wr_n <= wr_n_s;
         prev_rd_n <= rd_n_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         pos_q  <= '0;
      end else if (en_rise || sel_fall) begin
         pos_q <= '0;
      end else if (active && !sel_s && wr_rise) begin
         addr_q[(NIBS-1-int'(pos_q))*NIB_W +: NIB_W] <= data_s;
         pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
      end else if (data_evt && in_range && addr_q != CTRL_A) begin
         addr_q <= addr_q + 1'b1;
      end
   end

   assign addr_o  = addr_q;
   assign we_o    = active && sel_s && wr_rise && in_range;
   assign wdata_o = data_s;

   // R1
   disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_n_s |=> $stable(addr_q));
   // R2
   pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pos_q) < NIBS);
   // R3
   pos_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_fall |=> pos_q == '0);
   // R8
   addr_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_evt && addr_q >= CTRL_A) |=> $stable(addr_q));
endmodule

// File: rtl/nrp_store.sv
module nrp_store #(
   parameter int NIB_W     = 4,
   parameter int ADDR_W    = 12,
   parameter int DEPTH     = 2560
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [NIB_W-1:0]  wdata,
   output logic [NIB_W-1:0]  rdata,
   input  logic [ADDR_W-1:0] scan_addr,
   output logic [NIB_W-1:0]  scan_data,
   output nrp_pkg::nrp_ctrl_t ctrl_o
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(DEPTH);

   generate
      if (DEPTH >= (1 << ADDR_W)) begin : g_bad_depth
         $error("nrp_store: DEPTH leaves no room for the control word");
      end
      if (NIB_W != nrp_pkg::NRP_CTRL_W) begin : g_bad_ctrl_w
         $error("nrp_store: control word width must equal NIB_W");
      end
   endgenerate

   logic [NIB_W-1:0]   mem [DEPTH];
   nrp_pkg::nrp_ctrl_t ctrl_q;

   always_ff @(posedge clk) begin
      if (we && addr < CTRL_A) mem[addr[$clog2(DEPTH)-1:0]] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ctrl_q <= '0;
      else if (we && addr == CTRL_A) ctrl_q <= nrp_pkg::nrp_ctrl_t'(wdata);
   end

   function automatic logic [NIB_W-1:0] fetch(input logic [ADDR_W-1:0] a,
                                              input logic [NIB_W-1:0] m,
                                              input logic [NIB_W-1:0] c);
      if (a < CTRL_A)       return m;
      else if (a == CTRL_A) return c;
      else                  return '0;
   endfunction

   logic [NIB_W-1:0] host_word, scan_word;
   assign host_word = mem[addr[$clog2(DEPTH)-1:0]];
   assign scan_word = mem[scan_addr[$clog2(DEPTH)-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata     <= '0;
         scan_data <= '0;
      end else begin
         rdata     <= fetch(addr, host_word, ctrl_q);
         scan_data <= fetch(scan_addr, scan_word, ctrl_q);
      end
   end

   assign ctrl_o = ctrl_q;

   // R7
   ctrl_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q != $past(ctrl_q)) |-> $past(we && addr == CTRL_A));
   // R8
   we_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> addr <= CTRL_A);
endmodule

// File: rtl/nibble_ram_port.sv
module nibble_ram_port #(
   parameter int ADDR_W      = 12,
   parameter int DEPTH       = 2560,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          port_en_n,
   input  logic                          sel_data,
   input  logic                          wr_n,
   input  logic                          rd_n,
   inout  wire  [nrp_pkg::NRP_NIB_W-1:0] bus,
   input  logic [ADDR_W-1:0]             scan_addr,
   output logic [nrp_pkg::NRP_NIB_W-1:0] scan_data,
   output logic [2:0]                    reg_level,
   output logic                          bias_sel
);
   localparam int NIB_W = nrp_pkg::NRP_NIB_W;
   localparam int SW    = NIB_W + 4;
   localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, 1'b1, 1'b1, {NIB_W{1'b0}}};

   logic [SW-1:0]     sync_q;
   logic              en_n_s, sel_s, wr_n_s, rd_n_s;
   logic [NIB_W-1:0]  data_s, wdata, rdata;
   logic [ADDR_W-1:0] addr;
   logic              we, drive;
   nrp_pkg::nrp_ctrl_t ctrl;

   nrp_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({port_en_n, sel_data, wr_n, rd_n, bus}),
      .q(sync_q));

   assign {en_n_s, sel_s, wr_n_s, rd_n_s, data_s} = sync_q;

   nrp_seq #(.NIB_W(NIB_W), .ADDR_W(ADDR_W), .CTRL_ADDR(DEPTH)) u_seq (
      .clk(clk), .rst_n(rst_n), .en_n_s(en_n_s), .sel_s(sel_s),
      .wr_n_s(wr_n_s), .rd_n_s(rd_n_s), .data_s(data_s),
      .addr_o(addr), .we_o(we), .wdata_o(wdata));

   nrp_store #(.NIB_W(NIB_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
      .rdata(rdata), .scan_addr(scan_addr), .scan_data(scan_data),
      .ctrl_o(ctrl));

   assign drive     = !port_en_n && !rd_n && sel_data;
   assign bus       = drive ? rdata : {NIB_W{1'bz}};
   assign reg_level = ctrl.level;
   assign bias_sel  = ctrl.bias_sel;
endmodule

// File: tb/nibble_ram_port_tb_top.sv
`timescale 1ns/1ps
module nibble_ram_port_tb_top;
   localparam int CTRL = 2560;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        port_en_n = 1, sel_data = 0, wr_n = 1, rd_n = 1;
   logic [3:0]  tb_val = 0;
   logic        tb_oe = 0;
   wire  [3:0]  bus;
   logic [11:0] scan_addr = 0;
   logic [3:0]  scan_data;
   logic [2:0]  reg_level;
   logic        bias_sel;

   assign bus = tb_oe ? tb_val : 4'bzzzz;

   nibble_ram_port dut_i (
      .clk(clk), .rst_n(rst_n), .port_en_n(port_en_n), .sel_data(sel_data),
      .wr_n(wr_n), .rd_n(rd_n), .bus(bus), .scan_addr(scan_addr),
      .scan_data(scan_data), .reg_level(reg_level), .bias_sel(bias_sel));

   always #5 clk = ~clk;

   int n_run = 0, n_fail = 0;
   bit done = 0;
   int mem_m [0:CTRL];
   int addr_m = 0;

   function automatic int next_addr(input int a);
      return (a < CTRL) ? a + 1 : a;
   endfunction
   function automatic int exp_rd(input int a);
      return (a <= CTRL) ? mem_m[a] : 0;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clks(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic strobe_wr(input logic [3:0] v);
      tb_val = v; tb_oe = 1; clks(2);
      wr_n = 0; clks(4);
      wr_n = 1; clks(5);
      tb_oe = 0;
   endtask

   task automatic load_addr(input int a);
      sel_data = 0; clks(4);
      for (int i = 2; i >= 0; i--) strobe_wr(4'((a >> (4 * i)) & 15));
      sel_data = 1; clks(4);
      addr_m = a;
   endtask

   task automatic wr_data(input logic [3:0] v);
      strobe_wr(v);
      if (addr_m <= CTRL) begin
         mem_m[addr_m] = int'(v);
         addr_m = next_addr(addr_m);
      end
   endtask

   task automatic rd_check(input string req);
      int e;
      e = exp_rd(addr_m);
      rd_n = 0; clks(3); @(negedge clk);
      chk(int'(bus) == e, req, int'(bus), e);
      rd_n = 1; clks(5);
      if (addr_m <= CTRL) addr_m = next_addr(addr_m);
   endtask

   // bench drives v while the design must stay off the bus
   task automatic released_check(input logic [3:0] v, input string req);
      tb_val = v; tb_oe = 1; clks(3); @(negedge clk);
      chk(bus == v, req, int'(bus), int'(v));
      tb_oe = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i <= CTRL; i++) mem_m[i] = 0;
      clks(3); rst_n = 1; clks(2);
      @(negedge clk);
      // R10 reset state
      chk(reg_level == 0 && !bias_sel, "R10 ctrl reset", {bias_sel, reg_level}, 0);
      released_check(4'hA, "R10 bus idle after reset");
      port_en_n = 0; clks(4);

      // R2 nibble order
      load_addr(12'h123); wr_data(4'h5);
      load_addr(12'h321); wr_data(4'hA);
      load_addr(12'h123); rd_check("R2 order 0x123");
      load_addr(12'h321); rd_check("R2 order 0x321");

      // R4 write burst, R5 read burst
      load_addr(100);
      for (int i = 0; i < 8; i++) wr_data(4'(i * 3 + 1));
      load_addr(100);
      for (int i = 0; i < 8; i++) rd_check("R5 read burst / R4 write burst");

      // R3 restart via select falling
      load_addr(200); wr_data(4'h9);
      sel_data = 0; clks(4); strobe_wr(4'hF);
      sel_data = 1; clks(4);
      load_addr(200); rd_check("R3 restart on select fall");
      // R3 restart via enable rising
      sel_data = 0; clks(4); strobe_wr(4'hF);
      port_en_n = 1; clks(4); port_en_n = 0; clks(4);
      for (int i = 2; i >= 0; i--) strobe_wr(4'((200 >> (4 * i)) & 15));
      sel_data = 1; clks(4); addr_m = 200;
      rd_check("R3 restart on enable rise");

      // R1 disabled strobes
      load_addr(300); wr_data(4'h7);
      load_addr(300);
      port_en_n = 1; clks(4);
      strobe_wr(4'hE);
      rd_n = 0; released_check(4'h8, "R1 bus off while disabled"); rd_n = 1; clks(5);
      port_en_n = 0; clks(4);
      rd_check("R1 no write and no step while disabled");

      // R6 bus off with select low
      load_addr(300); sel_data = 0; clks(4);
      rd_n = 0; released_check(4'h8, "R6 bus off in address mode"); rd_n = 1; clks(5);
      sel_data = 1; clks(4);

      // R7 control word
      load_addr(CTRL); wr_data(4'hA);
      @(negedge clk);
      chk(reg_level == 3'd2 && bias_sel, "R7 ctrl fields", {bias_sel, reg_level}, 4'hA);
      load_addr(CTRL); rd_check("R7 ctrl readback");
      rd_check("R8 stays at ctrl after read");

      // R8 run into ctrl and saturate
      load_addr(2559); wr_data(4'h3); wr_data(4'h6);
      @(negedge clk);
      chk({bias_sel, reg_level} == 4'h6, "R8 burst into ctrl", {bias_sel, reg_level}, 6);
      wr_data(4'h9);
      @(negedge clk);
      chk({bias_sel, reg_level} == 4'h9, "R8 saturated write", {bias_sel, reg_level}, 9);
      load_addr(2559); rd_check("R8 last array nibble");
      load_addr(2561); strobe_wr(4'hF); clks(2);
      @(negedge clk);
      chk({bias_sel, reg_level} == 4'h9, "R8 ignored write above ctrl", {bias_sel, reg_level}, 9);
      rd_check("R8 read above ctrl"); rd_check("R8 read above ctrl repeat");
      load_addr(0); rd_check("R8 no wrap into location 0");

      // R9 scan port
      scan_addr = 12'd103; clks(2); @(negedge clk);
      chk(int'(scan_data) == mem_m[103], "R9 scan array", int'(scan_data), mem_m[103]);
      scan_addr = 12'(CTRL); clks(2); @(negedge clk);
      chk(int'(scan_data) == mem_m[CTRL], "R9 scan ctrl", int'(scan_data), mem_m[CTRL]);
      scan_addr = 12'd4000; clks(2); @(negedge clk);
      chk(scan_data == 0, "R9 scan above ctrl", int'(scan_data), 0);

      // random bursts
      for (int it = 0; it < 20; it++) begin
         int base, len;
         base = int'($urandom_range(0, 2551));
         len  = int'($urandom_range(1, 8));
         load_addr(base);
         for (int k = 0; k < len; k++) wr_data(4'($urandom_range(0, 15)));
         load_addr(base);
         for (int k = 0; k < len; k++) rd_check("R4 R5 random burst");
         scan_addr = 12'(base); clks(2); @(negedge clk);
         chk(int'(scan_data) == mem_m[base], "R9 random scan", int'(scan_data), mem_m[base]);
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule